// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Front End

This block is the register side of a serial port on a 32-bit processor bus. Each bus cycle the processor gives one word address plus two four-bit lane masks, one for the byte lanes it reads and one for the byte lanes it writes. The block claims a 52-byte window starting at a parameter base address. Inside that window sit four registers. A byte-wide data port pops received bytes when read and queues bytes for transmission when written. A 32-bit line control word can be read and written. A 32-bit status word is read-only and carries the receive and transmit ready flags.

Toward the serial side there are two 8-entry byte queues, each with a valid/ready handshake. One is filled by the receiver and one is drained by the transmitter. After each successful pop or push, the ready flag for that direction goes low for a programmable number of clock cycles. This models the time the line needs before the next byte.

The block also checks every bus cycle against the access rules. A word register must be touched on all four lanes or on none. The status word must never be written. The data port must not be used while its ready flag is low. A broken rule gives a one-cycle error pulse on the cycle after the access, and no state changes. A control word with bit 7 set raises a level configuration-error flag.

Top module: `serreg_front`

## Requirements
- R1: Addresses below the base or at base+0x34 and above, and in-window words other than offsets 0x00, 0x0C and 0x14, read as zero. Accesses to them raise no error and change no state.
- R2: Status word (offset 0x14) bit 0 is 1 exactly when the receive queue holds a byte and its delay has expired. Bit 5 is 1 exactly when the transmit delay has expired and the transmit queue has space. All other status bits read 0.
- R3: A read of lane 0 at offset 0x00 while status bit 0 is 1 returns the oldest received byte in rdData bits 7:0 and removes it from the receive queue. Bytes come out in arrival order.
- R4: A write of lane 0 at offset 0x00 while status bit 5 is 1 appends wrData bits 7:0 to the transmit queue. The transmitter sees the bytes in write order on txOutData.
- R5: After a successful pop (or push), status bit 0 (or bit 5) reads 0 for exactly READY_DELAY cycles (default 4) and may return on the following cycle.
- R6: A data read while bit 0 is 0, or a data write while bit 5 is 0, makes nrdyErr high for one cycle, on the cycle after the access. It changes neither queue, and the read returns 0.
- R7: The control word (offset 0x0C, reset value 0x00000003) takes wrData only when all four lanes are written. A read or write that covers 1 to 3 lanes makes accErr high on the next cycle, and a partial write leaves the value unchanged.
- R8: A write to any lane of the status word makes accErr high on the next cycle and leaves the status word unchanged. A partial read of the status word also raises accErr.
- R9: cfgErr equals bit 7 of the control word.
- R10: Word registers are little-endian: lane k carries bits 8k+7:8k. rdData lanes that are not read are 0.
- R11: rxInReady is 0 while the receive queue holds 8 bytes. txOutValid is 1 while the transmit queue is not empty.
- R12: After reset, the status word reads 0x20, the control word reads 0x00000003, both queues are empty and all error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 32 | Byte address of the accessed word (low two bits ignored) |
| rdLanes | input | 4 | Byte lanes read this cycle |
| wrLanes | input | 4 | Byte lanes written this cycle |
| wrData | input | 32 | Write data, lane k in bits 8k+7:8k |
| rdData | output | 32 | Read data for the current cycle, combinational |
| accErr | output | 1 | Access-rule error pulse, one cycle after the access |
| nrdyErr | output | 1 | Not-ready error pulse, one cycle after the access |
| cfgErr | output | 1 | Control word bit 7 is set |
| rxInValid | input | 1 | Serial side offers a received byte |
| rxInData | input | 8 | Received byte |
| rxInReady | output | 1 | Receive queue can accept a byte |
| txOutValid | output | 1 | Transmit queue has a byte |
| txOutData | output | 8 | Oldest byte to transmit |
| txOutReady | input | 1 | Serial side takes the byte |

## Verification
A queue pointer or count that drifts shows up at the ports within one access. Either a data read returns a byte out of arrival order, or txOutData gives the transmitter a byte it was never written, or the status bits disagree with how many bytes the bench has pushed. A wrong delay counter shows up as a status flag that comes back one cycle early or late, counted by polling the status word after each pop or push. Wrong decode of lane masks shows up on the cycle after the access as an error pulse that is missing or extra. It also shows up as a control word that changed after a partial write.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_DATA, SEL_CTRL, SEL_STAT} regSel_t;

  typedef struct packed {
    logic rxPop;
    logic txPush;
    logic ctrlWrite;
    logic accErr;
    logic nrdyErr;
  } strobe_t;

  localparam int WIN_BYTES = 52;
  localparam int IDX_DATA  = 0;
  localparam int IDX_CTRL  = 3;
  localparam int IDX_STAT  = 5;
  localparam int RX_RDY_BIT = 0;
  localparam int TX_RDY_BIT = 5;
  localparam int CFG_BIT    = 7;

  function automatic logic partialMask(input logic [3:0] m);
    return (m != 4'h0) && (m != 4'hF);
  endfunction
endpackage

// File: rtl/serreg_fifo.sv
module serreg_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W:0]   count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == (PTR_W+1)'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/serreg_ctrl.sv
module serreg_ctrl
  import serreg_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hE000_C000
) (
  input  logic [31:0] busAddr,
  input  logic [3:0]  rdLanes,
  input  logic [3:0]  wrLanes,
  input  logic        rxReady,
  input  logic        txReady,
  output regSel_t     sel,
  output strobe_t     strb
);
  logic [31:0] offset;
  logic        hit;
  logic [3:0]  wordIdx;

  assign offset  = busAddr - BASE_ADDR;
  assign hit     = (busAddr >= BASE_ADDR) && (offset < 32'(WIN_BYTES));
  assign wordIdx = offset[5:2];

  always_comb begin
    sel = SEL_NONE;
    if (hit) begin
      case (wordIdx)
        4'(IDX_DATA): sel = SEL_DATA;
        4'(IDX_CTRL): sel = SEL_CTRL;
        4'(IDX_STAT): sel = SEL_STAT;
        default:      sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    case (sel)
      SEL_DATA: begin
        if (rdLanes[0]) begin
          if (rxReady) strb.rxPop = 1'b1;
          else         strb.nrdyErr = 1'b1;
        end
        if (wrLanes[0]) begin
          if (txReady) strb.txPush = 1'b1;
          else         strb.nrdyErr = 1'b1;
        end
      end
      SEL_CTRL: begin
        if (partialMask(rdLanes) || partialMask(wrLanes)) strb.accErr = 1'b1;
        if (wrLanes == 4'hF) strb.ctrlWrite = 1'b1;
      end
      SEL_STAT: begin
        if (partialMask(rdLanes) || (wrLanes != 4'h0)) strb.accErr = 1'b1;
      end
      default: strb = '0;
    endcase
  end
endmodule

// File: rtl/serreg_dp.sv
module serreg_dp
  import serreg_pkg::*;
#(
  parameter int          FIFO_DEPTH  = 8,
  parameter int          READY_DELAY = 4,
  parameter logic [31:0] CTRL_RESET  = 32'h0000_0003
) (
  input  logic        clk,
  input  logic        rstN,
  input  regSel_t     sel,
  input  strobe_t     strb,
  input  logic [3:0]  rdLanes,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        accErr,
  output logic        nrdyErr,
  output logic        cfgErr,
  output logic        rxReady,
  output logic        txReady,
  input  logic        rxInValid,
  input  logic [7:0]  rxInData,
  output logic        rxInReady,
  output logic        txOutValid,
  output logic [7:0]  txOutData,
  input  logic        txOutReady
);
  localparam int DLY_W = $clog2(READY_DELAY + 1);

  logic [31:0]      ctrlReg;
  logic [DLY_W-1:0] rxDly, txDly;
  logic [7:0]       rxHead;
  logic             rxEmpty, rxFull, txEmpty, txFull;
  logic [31:0]      statWord, wordOut;

  serreg_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rstN(rstN),
    .push(rxInValid), .pushData(rxInData),
    .pop(strb.rxPop), .head(rxHead),
    .empty(rxEmpty), .full(rxFull)
  );

  serreg_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rstN(rstN),
    .push(strb.txPush), .pushData(wrData[7:0]),
    .pop(txOutReady), .head(txOutData),
    .empty(txEmpty), .full(txFull)
  );

  assign rxInReady  = !rxFull;
  assign txOutValid = !txEmpty;
  assign rxReady    = (rxDly == '0) && !rxEmpty;
  assign txReady    = (txDly == '0) && !txFull;
  assign cfgErr     = ctrlReg[CFG_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
      rxDly   <= '0;
      txDly   <= '0;
      accErr  <= 1'b0;
      nrdyErr <= 1'b0;
    end else begin
      if (strb.ctrlWrite) ctrlReg <= wrData;
      if (strb.rxPop)        rxDly <= DLY_W'(READY_DELAY);
      else if (rxDly != '0)  rxDly <= rxDly - 1'b1;
      if (strb.txPush)       txDly <= DLY_W'(READY_DELAY);
      else if (txDly != '0)  txDly <= txDly - 1'b1;
      accErr  <= strb.accErr;
      nrdyErr <= strb.nrdyErr;
    end
  end

  always_comb begin
    statWord = '0;
    statWord[RX_RDY_BIT] = rxReady;
    statWord[TX_RDY_BIT] = txReady;
  end

  always_comb begin
    case (sel)
      SEL_DATA: wordOut = {24'h0, rxReady ? rxHead : 8'h00};
      SEL_CTRL: wordOut = ctrlReg;
      SEL_STAT: wordOut = statWord;
      default:  wordOut = '0;
    endcase
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign rdData[8*k +: 8] = rdLanes[k] ? wordOut[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/serreg_front.sv
module serreg_front
  import serreg_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR   = 32'hE000_C000,
  parameter int          FIFO_DEPTH  = 8,
  parameter int          READY_DELAY = 4,
  parameter logic [31:0] CTRL_RESET  = 32'h0000_0003
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] busAddr,
  input  logic [3:0]  rdLanes,
  input  logic [3:0]  wrLanes,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        accErr,
  output logic        nrdyErr,
  output logic        cfgErr,
  input  logic        rxInValid,
  input  logic [7:0]  rxInData,
  output logic        rxInReady,
  output logic        txOutValid,
  output logic [7:0]  txOutData,
  input  logic        txOutReady
);
  regSel_t sel;
  strobe_t strb;
  logic    rxReady, txReady;

  serreg_ctrl #(.BASE_ADDR(BASE_ADDR)) u_ctrl (
    .busAddr(busAddr), .rdLanes(rdLanes), .wrLanes(wrLanes),
    .rxReady(rxReady), .txReady(txReady),
    .sel(sel), .strb(strb)
  );

  serreg_dp #(
    .FIFO_DEPTH(FIFO_DEPTH), .READY_DELAY(READY_DELAY), .CTRL_RESET(CTRL_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sel(sel), .strb(strb),
    .rdLanes(rdLanes), .wrData(wrData), .rdData(rdData),
    .accErr(accErr), .nrdyErr(nrdyErr), .cfgErr(cfgErr),
    .rxReady(rxReady), .txReady(txReady),
    .rxInValid(rxInValid), .rxInData(rxInData), .rxInReady(rxInReady),
    .txOutValid(txOutValid), .txOutData(txOutData), .txOutReady(txOutReady)
  );
endmodule

// File: rtl/serreg_checks.sv
module serreg_checks
  import serreg_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hE000_C000
) (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] busAddr,
  input logic [3:0]  rdLanes,
  input logic [3:0]  wrLanes,
  input logic [31:0] wrData,
  input logic        accErr,
  input logic        nrdyErr,
  input logic        cfgErr,
  input logic        rxReady
);
  logic [31:0] off;
  logic        inWin;
  logic [3:0]  idx;
  assign off   = busAddr - BASE_ADDR;
  assign inWin = (busAddr >= BASE_ADDR) && (off < 32'(WIN_BYTES));
  assign idx   = off[5:2];

  p_outside_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |=> (!accErr && !nrdyErr));

  p_rx_flag_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && idx == 4'(IDX_DATA) && rdLanes[0] && rxReady) |=> !rxReady);

  p_not_ready_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && idx == 4'(IDX_DATA) && rdLanes[0] && !rxReady) |=> nrdyErr);

  p_ctrl_partial_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && idx == 4'(IDX_CTRL) && wrLanes != 4'h0 && wrLanes != 4'hF) |=> accErr);

  p_stat_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && idx == 4'(IDX_STAT) && wrLanes != 4'h0) |=> accErr);

  p_cfg_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && idx == 4'(IDX_CTRL) && wrLanes == 4'hF) |=> (cfgErr == $past(wrData[7])));
endmodule

bind serreg_front serreg_checks #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .rdLanes(rdLanes),
  .wrLanes(wrLanes), .wrData(wrData), .accErr(accErr), .nrdyErr(nrdyErr),
  .cfgErr(cfgErr), .rxReady(rxReady)
);

// File: tb/serreg_front_bench.sv
`timescale 1ns/1ps
module serreg_front_bench;
  localparam logic [31:0] BASE = 32'hE000_C000;
  localparam logic [31:0] A_DATA = BASE + 32'h00;
  localparam logic [31:0] A_CTRL = BASE + 32'h0C;
  localparam logic [31:0] A_STAT = BASE + 32'h14;

  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] busAddr = '0, wrData = '0, rdData;
  logic [3:0]  rdLanes = '0, wrLanes = '0;
  logic accErr, nrdyErr, cfgErr;
  logic rxInValid = 1'b0, rxInReady, txOutValid, txOutReady = 1'b0;
  logic [7:0] rxInData = '0, txOutData;

  int checks = 0, errors = 0;
  logic [7:0] txExp[$];
  logic [7:0] rxExp[$];

  always #10 clk = ~clk;

  serreg_front u_serreg_front (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .rdLanes(rdLanes),
    .wrLanes(wrLanes), .wrData(wrData), .rdData(rdData),
    .accErr(accErr), .nrdyErr(nrdyErr), .cfgErr(cfgErr),
    .rxInValid(rxInValid), .rxInData(rxInData), .rxInReady(rxInReady),
    .txOutValid(txOutValid), .txOutData(txOutData), .txOutReady(txOutReady)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: a transfer happens at the posedge after this negedge.
  always @(negedge clk) begin
    if (rstN && txOutValid && txOutReady) begin
      if (txExp.size() == 0) check(1'b0, "R4 unexpected tx byte", 32'(txOutData), 32'h0);
      else begin
        logic [7:0] e;
        e = txExp.pop_front();
        check(txOutData == e, "R4 tx order", 32'(txOutData), 32'(e));
      end
    end
  end

  // One bus cycle; called at a negedge, returns at the next negedge.
  task automatic busOp(input logic [31:0] a, input logic [3:0] rl, input logic [3:0] wl,
                       input logic [31:0] d, output logic [31:0] rd,
                       output logic ae, output logic ne);
    busAddr = a; rdLanes = rl; wrLanes = wl; wrData = d;
    #5 rd = rdData;
    @(negedge clk);
    ae = accErr; ne = nrdyErr;
    rdLanes = '0; wrLanes = '0;
  endtask

  task automatic readStat(output logic [31:0] s);
    logic ae, ne;
    busOp(A_STAT, 4'hF, 4'h0, '0, s, ae, ne);
  endtask

  task automatic waitBit(input int bitNo, input int limit, output int waited, output bit seen);
    logic [31:0] s;
    waited = 0; seen = 0;
    for (int i = 0; i < limit; i++) begin
      readStat(s);
      if (s[bitNo]) begin seen = 1; break; end
      waited++;
    end
  endtask

  task automatic feedRx(input logic [7:0] b, output bit taken);
    rxInValid = 1'b1; rxInData = b;
    #5 taken = rxInReady;
    @(negedge clk);
    rxInValid = 1'b0;
    if (taken) rxExp.push_back(b);
  endtask

  task automatic popRx(input string tag);
    logic [31:0] rd; logic ae, ne; int w; bit seen;
    waitBit(0, 20, w, seen);
    busOp(A_DATA, 4'h1, 4'h0, '0, rd, ae, ne);
    if (rxExp.size() == 0) check(1'b0, tag, rd, 32'h0);
    else begin
      logic [7:0] e;
      e = rxExp.pop_front();
      check(seen && rd == 32'(e) && !ne, tag, rd, 32'(e));
    end
  endtask

  task automatic pushTx(input logic [7:0] b, input string tag);
    logic [31:0] rd; logic ae, ne; int w; bit seen;
    waitBit(5, 20, w, seen);
    check(seen, tag, 32'(seen), 32'h1);
    if (seen) txExp.push_back(b);
    busOp(A_DATA, 4'h0, 4'h1, {24'hA5A5A5, b}, rd, ae, ne);
    check(!ne && !ae, tag, {ae, ne}, 32'h0);
  endtask

  initial begin
    logic [31:0] rd, s; logic ae, ne; int w; bit seen, taken;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12 reset state
    readStat(s);
    check(s == 32'h20, "R12 status after reset", s, 32'h20);
    busOp(A_CTRL, 4'hF, 4'h0, '0, rd, ae, ne);
    check(rd == 32'h3 && !cfgErr && !ae && !ne, "R12 ctrl after reset", rd, 32'h3);
    check(!txOutValid && rxInReady, "R12 R11 queues empty", {txOutValid, rxInReady}, 32'h1);

    // R6 read while nothing received
    busOp(A_DATA, 4'h1, 4'h0, '0, rd, ae, ne);
    check(ne && rd == 0 && !ae, "R6 read not ready", {ne, rd[30:0]}, 32'h8000_0000);
    check(rxExp.size() == 0, "R6 queue untouched", 32'(rxExp.size()), 0);

    // R3 R2 R5 receive path
    feedRx(8'h11, taken); feedRx(8'h22, taken); feedRx(8'h33, taken);
    readStat(s);
    check(s == 32'h21, "R2 rx flag set", s, 32'h21);
    busOp(A_DATA, 4'h1, 4'h0, '0, rd, ae, ne);
    check(rd == 32'h11 && !ne, "R3 first rx byte", rd, 32'h11);
    void'(rxExp.pop_front());
    waitBit(0, 20, w, seen);
    check(seen && w == 4, "R5 rx delay cycles", 32'(w), 32'd4);
    popRx("R3 second rx byte");
    popRx("R3 third rx byte");
    readStat(s);
    check(s[0] == 1'b0, "R2 rx flag clear when empty", s, 32'h20);

    // R4 R5 R6 transmit path
    txOutReady = 1'b1;
    pushTx(8'h5A, "R4 push 1");
    busOp(A_DATA, 4'h0, 4'h1, 32'h77, rd, ae, ne);
    check(ne, "R6 write not ready", 32'(ne), 32'h1);
    waitBit(5, 20, w, seen);
    check(seen && w == 3, "R5 tx delay cycles", 32'(w), 32'd3);
    pushTx(8'hC3, "R4 push 2");
    repeat (3) @(negedge clk);
    check(txExp.size() == 0 && !txOutValid, "R4 R6 tx drained", 32'(txExp.size()), 0);

    // R11 R2 transmit queue full
    @(posedge clk); #2 txOutReady = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) pushTx(8'(8'h40 + i), "R4 fill tx");
    check(txOutValid, "R11 txOutValid", 32'(txOutValid), 32'h1);
    waitBit(5, 10, w, seen);
    check(!seen, "R2 tx flag low while full", 32'(seen), 32'h0);
    @(posedge clk); #2 txOutReady = 1'b1;
    repeat (12) @(negedge clk);
    check(txExp.size() == 0, "R4 tx drained in order", 32'(txExp.size()), 0);

    // R7 R10 control word
    busOp(A_CTRL, 4'h0, 4'hF, 32'h1234_5678, rd, ae, ne);
    check(!ae && !cfgErr, "R7 full write", {ae, cfgErr}, 32'h0);
    busOp(A_CTRL, 4'h4, 4'h0, '0, rd, ae, ne);
    check(rd == 32'h0034_0000, "R10 lane 2", rd, 32'h0034_0000);
    check(ae, "R7 partial read error", 32'(ae), 32'h1);
    busOp(A_CTRL, 4'h0, 4'h1, 32'hFFFF_FFFF, rd, ae, ne);
    check(ae, "R7 partial write error", 32'(ae), 32'h1);
    busOp(A_CTRL, 4'hF, 4'h0, '0, rd, ae, ne);
    check(rd == 32'h1234_5678 && !ae && !cfgErr, "R7 value kept", rd, 32'h1234_5678);

    // R9 configuration flag
    busOp(A_CTRL, 4'h0, 4'hF, 32'h0000_0080, rd, ae, ne);
    check(cfgErr, "R9 bit7 set", 32'(cfgErr), 32'h1);
    busOp(A_CTRL, 4'h0, 4'hF, 32'h0000_0003, rd, ae, ne);
    check(!cfgErr, "R9 bit7 clear", 32'(cfgErr), 32'h0);

    // R8 status writes
    busOp(A_STAT, 4'h0, 4'h1, 32'h0000_0001, rd, ae, ne);
    check(ae, "R8 status write error", 32'(ae), 32'h1);
    busOp(A_STAT, 4'h3, 4'h0, '0, rd, ae, ne);
    check(ae, "R8 partial status read", 32'(ae), 32'h1);
    readStat(s);
    check(s == 32'h20, "R8 status unchanged", s, 32'h20);

    // R1 unclaimed addresses
    busOp(BASE + 32'h34, 4'hF, 4'hF, 32'hDEAD_BEEF, rd, ae, ne);
    check(rd == 0 && !ae && !ne, "R1 above window", rd, 32'h0);
    busOp(BASE - 32'h4, 4'hF, 4'hF, 32'hDEAD_BEEF, rd, ae, ne);
    check(rd == 0 && !ae && !ne, "R1 below window", rd, 32'h0);
    busOp(BASE + 32'h08, 4'hF, 4'hF, 32'hDEAD_BEEF, rd, ae, ne);
    check(rd == 0 && !ae && !ne, "R1 unmapped in window", rd, 32'h0);
    busOp(A_CTRL, 4'hF, 4'h0, '0, rd, ae, ne);
    check(rd == 32'h3 && !txOutValid, "R1 no state change", rd, 32'h3);

    // R11 receive queue full, then drain in order
    for (int i = 0; i < 8; i++) feedRx(8'(8'h80 + i), taken);
    check(!rxInReady, "R11 rxInReady low when full", 32'(rxInReady), 32'h0);
    feedRx(8'hEE, taken);
    check(!taken, "R11 extra byte refused", 32'(taken), 32'h0);
    for (int i = 0; i < 8; i++) popRx("R3 drain full queue");
    check(rxInReady && rxExp.size() == 0, "R11 R3 rx queue empty", 32'(rxExp.size()), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule